// File: doc/BRIEF.md
# Fuse-Programmable Product-Term Array with Fixed OR Pairs

This block emulates a small programmable logic array in which the AND plane is configurable and the OR plane is fixed. Each of ten inputs drives two columns, one true and one complemented. Each of sixteen product terms picks any subset of those twenty columns, as chosen by a static fuse map. Consecutive pairs of terms are ORed to form eight active-high outputs.

The fuse map is a flat configuration vector with one bit per fuse. A set bit models an intact fuse, and an intact fuse keeps its literal in the term. A clear bit models a blown fuse, which drops the literal. An array that has not been programmed (all bits set) therefore gives constant-low terms. To disable a spare term, leave all of its fuses intact. The block contains no storage and no clock, so every output follows its inputs combinationally.

Top module: `pal_fixed_or`

## Requirements
- R1: The block has ten inputs, sixteen product terms and eight active-high outputs. Output k is the OR of term 2k and term 2k+1, and no other term feeds it.
- R2: Fuse bit [t*20 + 2*i] is the true literal of input i in term t, and bit [t*20 + 2*i + 1] is its complement literal. A bit value of 1 (intact) keeps the literal in the term, and 0 (blown) removes it.
- R3: When both fuse rows of an output are entirely 1, that output is low for every input value.
- R4: A term in which both the true and the complement literal of the same input are intact evaluates low, whatever the other fuses and inputs are.
- R5: A term with every fuse at 0 has no literals and evaluates high for every input value.
- R6: The outputs are purely combinational. A change on the inputs or the fuse map is visible in the same cycle, with no clock.
- R7: A term programmed with one literal per input matches exactly one 10-bit input value. With the partner term disabled, its output is high only for that value.
- R8: The fuse rows of one output pair have no effect on any other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sig_in | input | 10 | Logic inputs feeding the true and complement columns |
| fuse_map | input | 320 | Static fuse configuration, 20 bits per term, term 0 in the least significant bits |
| sig_out | output | 8 | Active-high outputs, each the OR of one fixed pair of terms |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the ports. The bench applies new inputs and a new fuse map just after a rising edge of its own clock. It compares all eight outputs against a behavioural model at the falling edge half a period later, when the combinational paths have settled. The model is evaluated once per clock with loop-based integer code. Directed cases cover the unprogrammed map, the all-blown map, single-literal terms, contradictory literals and a full 1024-value address sweep; random fuse maps follow.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int PAL_INPUTS    = 10;
    localparam int PAL_TERMS     = 16;
    localparam int PAL_PER_OUT   = 2;
    localparam int PAL_OUTPUTS   = PAL_TERMS / PAL_PER_OUT;
    localparam int PAL_COLS      = 2 * PAL_INPUTS;
    localparam int PAL_FUSE_BITS = PAL_TERMS * PAL_COLS;

    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_COMP = 1'b1
    } lit_pol_e;

    // Column index of a literal within one term row
    function automatic int col_index(input int inp, input lit_pol_e pol);
        return 2 * inp + int'(pol);
    endfunction

    // First fuse bit of a term row
    function automatic int row_base(input int term, input int cols);
        return term * cols;
    endfunction
endpackage

// File: rtl/pal_literal_gen.sv
module pal_literal_gen
    import pal_pkg::*;
#(
    parameter int N_IN = PAL_INPUTS,
    localparam int N_COL = 2 * N_IN
) (
    input  logic [N_IN-1:0]  sig_in,
    output logic [N_COL-1:0] cols
);
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign cols[col_index(i, POL_TRUE)] = sig_in[i];
        assign cols[col_index(i, POL_COMP)] = ~sig_in[i];
    end
endmodule

// File: rtl/pal_product_term.sv
module pal_product_term
    import pal_pkg::*;
#(
    parameter int N_IN = PAL_INPUTS,
    localparam int N_COL = 2 * N_IN
) (
    input  logic [N_IN-1:0]  sig_in,
    input  logic [N_COL-1:0] cols,
    input  logic [N_COL-1:0] fuse_row,
    output logic             term
);
    logic [N_IN-1:0] keep_true;
    logic [N_IN-1:0] keep_comp;

    for (genvar i = 0; i < N_IN; i++) begin : g_split
        assign keep_true[i] = fuse_row[col_index(i, POL_TRUE)];
        assign keep_comp[i] = fuse_row[col_index(i, POL_COMP)];
    end

    // A blown fuse forces its column to 1 in the wide AND
    assign term = &(cols | ~fuse_row);

    always_comb begin
        // R4: contradictory literals pin the term low
        p_contra_low_r4: assert ((keep_true & keep_comp) == '0 || !term)
            else $error("R4: term high with both polarities intact");
        // R5: no literals means the term is high
        p_empty_high_r5: assert (fuse_row != '0 || term)
            else $error("R5: empty term not high");
        // R2: a high term agrees with every kept literal
        p_lit_agree_r2: assert (!term ||
                                ((&(sig_in | ~keep_true)) && (&(~sig_in | ~keep_comp))))
            else $error("R2: term high against a kept literal");
    end
endmodule

// File: rtl/pal_or_pairs.sv
module pal_or_pairs
    import pal_pkg::*;
#(
    parameter int N_TERMS = PAL_TERMS,
    parameter int PER_OUT = PAL_PER_OUT,
    localparam int N_OUT = N_TERMS / PER_OUT
) (
    input  logic [N_TERMS-1:0] terms,
    output logic [N_OUT-1:0]   outs
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_or
        assign outs[k] = |terms[k*PER_OUT +: PER_OUT];
    end
endmodule

// File: rtl/pal_fixed_or.sv
module pal_fixed_or
    import pal_pkg::*;
#(
    parameter int N_IN    = PAL_INPUTS,
    parameter int N_TERMS = PAL_TERMS,
    parameter int PER_OUT = PAL_PER_OUT,
    localparam int N_COL  = 2 * N_IN,
    localparam int N_OUT  = N_TERMS / PER_OUT,
    localparam int N_FUSE = N_TERMS * N_COL
) (
    input  logic [N_IN-1:0]   sig_in,
    input  logic [N_FUSE-1:0] fuse_map,
    output logic [N_OUT-1:0]  sig_out
);
    logic [N_COL-1:0]   cols;
    logic [N_TERMS-1:0] terms;

    pal_literal_gen #(.N_IN(N_IN)) u_lit (
        .sig_in (sig_in),
        .cols   (cols)
    );

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        pal_product_term #(.N_IN(N_IN)) u_pt (
            .sig_in   (sig_in),
            .cols     (cols),
            .fuse_row (fuse_map[row_base(t, N_COL) +: N_COL]),
            .term     (terms[t])
        );
    end

    pal_or_pairs #(.N_TERMS(N_TERMS), .PER_OUT(PER_OUT)) u_or (
        .terms (terms),
        .outs  (sig_out)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
        localparam int LO = row_base(k * PER_OUT, N_COL);
        always_comb begin
            // R3: an output whose rows are fully intact stays low
            p_unprog_low_r3: assert (!(&fuse_map[LO +: PER_OUT*N_COL]) || !sig_out[k])
                else $error("R3: unprogrammed output high");
        end
    end
endmodule

// File: tb/pal_fixed_or_tb_top.sv
module pal_fixed_or_tb_top;
    localparam int NI = 10;
    localparam int NT = 16;
    localparam int NO = 8;
    localparam int NF = NT * 2 * NI;

    logic          clk = 1'b0;
    logic [NI-1:0] sig_in = '0;
    logic [NF-1:0] fuse_map = '1;
    logic [NO-1:0] sig_out;
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pal_fixed_or dut_i (.sig_in(sig_in), .fuse_map(fuse_map), .sig_out(sig_out));

    function automatic logic [NO-1:0] model(input logic [NF-1:0] f, input logic [NI-1:0] x);
        logic [NO-1:0] r = '0;
        for (int t = 0; t < NT; t++) begin
            bit hit = 1;
            for (int c = 0; c < 2*NI; c++) begin
                if (f[t*2*NI + c]) begin
                    bit lit = (c % 2 == 1) ? !x[c/2] : x[c/2];
                    if (!lit) hit = 0;
                end
            end
            if (hit) r[t/2] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [NO-1:0] exp);
        n_cmp++;
        if (sig_out !== exp) begin
            n_bad++;
            $display("FAIL %s in=%h actual=%b expected=%b", req, sig_in, sig_out, exp);
        end
    endtask

    // Drive after a rising edge, compare at the falling edge of the same cycle
    task automatic apply(input string req, input logic [NF-1:0] f, input logic [NI-1:0] x);
        @(posedge clk);
        fuse_map <= f;
        sig_in   <= x;
        @(negedge clk);
        check(req, model(f, x));
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [NF-1:0] set_row(input logic [NF-1:0] f, input int t,
                                              input logic [2*NI-1:0] row);
        logic [NF-1:0] g = f;
        g[t*2*NI +: 2*NI] = row;
        return g;
    endfunction

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [NF-1:0] f;
        logic [2*NI-1:0] row;
        logic [NI-1:0] addr;

        // R3: unprogrammed map holds every output low
        @(negedge clk);
        check("R3", '0);
        for (int v = 0; v < 40; v++) apply("R3", '1, NI'(v * 37));

        // R5: all fuses blown gives all outputs high
        for (int v = 0; v < 20; v++) apply("R5", '0, NI'(v * 53));

        // R2: single true literal of input 4 in term 0, complement in term 2
        f = '1;
        row = '0; row[2*4] = 1'b1;       f = set_row(f, 0, row);
        row = '0; row[2*4 + 1] = 1'b1;   f = set_row(f, 2, row);
        apply("R2", f, 10'h010);
        check("R2", 8'b0000_0001);
        apply("R2", f, 10'h3EF);
        check("R2", 8'b0000_0010);

        // R4: both polarities of input 0 intact, all else blown
        f = '0;
        row = '0; row[0] = 1'b1; row[1] = 1'b1;
        f = set_row(f, 8, row);
        f = set_row(f, 9, row);
        for (int v = 0; v < 8; v++) apply("R4", f, NI'(v * 131));
        apply("R4", f, 10'h3FF);
        check("R4", 8'b1110_1111);

        // R7: address match on output 3, term 7 left intact (disabled)
        addr = 10'h2B5;
        f = '1;
        row = '0;
        for (int i = 0; i < NI; i++) row[2*i + (addr[i] ? 0 : 1)] = 1'b1;
        f = set_row(f, 6, row);
        for (int v = 0; v < 1024; v++) begin
            apply("R7", f, NI'(v));
            n_cmp++;
            if (sig_out[3] !== (NI'(v) == addr)) begin
                n_bad++;
                $display("FAIL R7 in=%h actual=%b expected=%b", v[NI-1:0], sig_out[3], NI'(v) == addr);
            end
        end

        // R8: output 3 programmed, others blown; others stay high
        f = '0;
        f = set_row(f, 6, row);
        f = set_row(f, 7, '1);
        apply("R8", f, 10'h000);
        check("R8", 8'b1111_0111);
        apply("R8", f, addr);
        check("R8", 8'b1111_1111);

        // R6: change in one cycle seen in the same cycle
        apply("R6", '0, 10'h155);
        apply("R6", '1, 10'h155);
        check("R6", '0);

        // R1: random sparse maps against the model
        for (int n = 0; n < 600; n++) begin
            f = '0;
            for (int w = 0; w < NF/32; w++) f[w*32 +: 32] = $urandom & $urandom & $urandom;
            apply("R1", f, NI'($urandom));
        end
        report();
    end
endmodule